// File: doc/BRIEF.md
# Accumulator Microsequencer

This block steps through a program of 12-bit instruction words, one instruction at a time, and applies each one to a 24-bit accumulator. The top four bits of a word select the operation and the low eight bits are its data field. Some operations read an 8-bit register from an external register space, and one writes the accumulator's low byte back to it. The register space is reached through an address output, a read-data input that answers one cycle after the address, and a write-data output with a write strobe. Program words come from a memory that also answers one cycle after the program counter is presented.

The operations are:
- loading a register into the low byte;
- forcing a single low-byte bit to 0 or 1;
- an unsigned add lined up with the low byte;
- a signed add and a signed subtract lined up with the middle byte;
- storing the low byte;
- a timed stall.

There is no branching, so the program counter only counts upward and wraps. A synchronous reset returns the sequencer to address zero with a cleared accumulator.

Top module: `acc_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `prog_addr` is 0, `acc_o` is 0 and `reg_we` is 0. A reset asserted mid-program has the same effect.
- R2: Opcode 4'h3 reads the register at the data-field address and places it in `acc_o[7:0]`, leaving `acc_o[23:8]` unchanged.
- R3: Opcode 4'h4 writes field bit 7 into the accumulator bit selected by field bits [2:0], where 0 means bit 0 and 7 means bit 7. Field bits [6:3] have no effect, and all other accumulator bits are unchanged.
- R4: Opcode 4'h5 adds the addressed register, zero-extended, to the accumulator at bits [7:0]. A carry propagates into the upper bits.
- R5: Opcode 4'h6 sign-extends the addressed register, multiplies it by 256 (placing it at bits [15:8] with zeros below), and adds the result to the accumulator.
- R6: Opcode 4'h7 forms the same signed value times 256 and subtracts it from the accumulator.
- R7: Opcode 4'h8 writes `acc_o[7:0]` to the register at the data-field address with a single-cycle `reg_we` pulse, and leaves the accumulator unchanged.
- R8: Opcode 4'h9 treats the data field as an unsigned count N. The instruction lasts N+2 cycles, including N = 0 and N = 255.
- R9: Opcodes 4'h0–4'h2 and 4'hA–4'hF change neither the accumulator nor any register, and last 2 cycles.
- R10: All accumulator arithmetic wraps modulo 2^24, in both directions.
- R11: `prog_addr` advances by exactly one per instruction. Register-reading instructions (4'h3, 4'h5, 4'h6, 4'h7) last 3 cycles, and set-bit and store last 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | 8 | Program counter presented to program memory |
| prog_data | input | 12 | Instruction word, valid one cycle after `prog_addr` |
| reg_addr | output | 8 | Register-space address (the data field) |
| reg_rdata | input | 8 | Register read data, valid one cycle after `reg_addr` |
| reg_wdata | output | 8 | Register write data (accumulator low byte) |
| reg_we | output | 1 | Register write strobe, one cycle per store |
| acc_o | output | 24 | Current accumulator value |

## Verification
The end of an instruction is defined as the edge at which `prog_addr` advances. At that edge the accumulator result and any register write are already visible. This happens two edges after the fetch begins for set-bit, store, no-op and a zero-count stall, three edges after for the register-reading operations, and N+2 edges after for a stall of N.

The bench writes each instruction into its program model just before the word is fetched. It then counts falling edges until `prog_addr` moves, compares that count with the expected duration, and compares the accumulator and register contents at that same falling edge. Expected accumulator values come from integer arithmetic on the bench's own copy of the register space.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_LOAD  = 4'h3;
    localparam logic [OP_W-1:0] OP_SETB  = 4'h4;
    localparam logic [OP_W-1:0] OP_ADDU  = 4'h5;
    localparam logic [OP_W-1:0] OP_ADDS  = 4'h6;
    localparam logic [OP_W-1:0] OP_SUBS  = 4'h7;
    localparam logic [OP_W-1:0] OP_STORE = 4'h8;
    localparam logic [OP_W-1:0] OP_WAIT  = 4'h9;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_READ  = 2'd2,
        ST_WAIT  = 2'd3
    } state_e;

    // Operations that need a register-space read before they can complete
    function automatic logic op_reads(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_ADDU) ||
               (op == OP_ADDS) || (op == OP_SUBS);
    endfunction

    // Operations allowed to touch accumulator bits above the low byte
    function automatic logic op_wide(input logic [OP_W-1:0] op);
        return (op == OP_ADDU) || (op == OP_ADDS) || (op == OP_SUBS);
    endfunction

endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
    import acc_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OP_W-1:0]  op,
    input  logic [DW-1:0]    fld,
    input  logic [3*DW-1:0]  acc,
    input  logic [DW-1:0]    opnd,
    output logic [3*DW-1:0]  res
);
    localparam int ACC_W = 3 * DW;
    localparam int SEL_W = $clog2(DW);

    logic [ACC_W-1:0] zext_low;
    logic [ACC_W-1:0] sext_mid;
    logic [SEL_W-1:0] bit_sel;
    logic             bit_val;

    assign zext_low = {{(2*DW){1'b0}}, opnd};
    assign sext_mid = {{DW{opnd[DW-1]}}, opnd, {DW{1'b0}}};
    assign bit_sel  = fld[SEL_W-1:0];
    assign bit_val  = fld[DW-1];

    always_comb begin
        res = acc;
        unique case (op)
            OP_LOAD: res = {acc[ACC_W-1:DW], opnd};
            OP_SETB: begin
                for (int i = 0; i < DW; i++) begin
                    if (bit_sel == SEL_W'(i)) begin
                        res[i] = bit_val;
                    end
                end
            end
            OP_ADDU: res = acc + zext_low;
            OP_ADDS: res = acc + sext_mid;
            OP_SUBS: res = acc - sext_mid;
            default: res = acc;
        endcase
    end

    // R2 R3: load and set-bit keep the upper accumulator bits
    always_comb begin
        if (op == OP_LOAD || op == OP_SETB) begin
            upper_keep_chk: assert (res[ACC_W-1:DW] == acc[ACC_W-1:DW])
                else $error("upper accumulator bits altered by low-byte op");
        end
    end

endmodule

// File: rtl/acc_seq_wait.sv
module acc_seq_wait #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(1));

    // R8
    property no_reload_chk_p;
        @(posedge clk) disable iff (rst) load |-> (cnt_q == '0);
    endproperty
    no_reload_chk: assert property (no_reload_chk_p)
        else $error("stall counter reloaded while still counting");

endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_seq_pkg::*;
#(
    parameter int PC_W = 8,
    parameter int DW   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [PC_W-1:0]      prog_addr,
    input  logic [OP_W+DW-1:0]   prog_data,
    output logic [DW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_rdata,
    output logic [DW-1:0]        reg_wdata,
    output logic                 reg_we,
    output logic [3*DW-1:0]      acc_o
);
    localparam int ACC_W = 3 * DW;
    localparam int IW    = OP_W + DW;

    typedef struct packed {
        state_e            st;
        logic [PC_W-1:0]   pc;
        logic [ACC_W-1:0]  acc;
        logic [IW-1:0]     ir;
    } seq_t;

    localparam seq_t RST_VAL = '{st: ST_FETCH, pc: '0, acc: '0, ir: '0};

    seq_t r_d, r_q;

    logic [OP_W-1:0]  cur_op;
    logic [DW-1:0]    cur_fld;
    logic [ACC_W-1:0] alu_res;
    logic             wait_load;
    logic             wait_last;
    logic             we_c;

    // In EXEC the word comes straight from program memory; later it is held
    assign cur_op  = (r_q.st == ST_EXEC) ? prog_data[IW-1:DW] : r_q.ir[IW-1:DW];
    assign cur_fld = (r_q.st == ST_EXEC) ? prog_data[DW-1:0]  : r_q.ir[DW-1:0];

    acc_seq_alu #(.DW(DW)) u_alu (
        .op   (cur_op),
        .fld  (cur_fld),
        .acc  (r_q.acc),
        .opnd (reg_rdata),
        .res  (alu_res)
    );

    acc_seq_wait #(.CW(DW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (cur_fld),
        .last     (wait_last)
    );

    always_comb begin
        r_d       = r_q;
        wait_load = 1'b0;
        we_c      = 1'b0;
        unique case (r_q.st)
            ST_FETCH: begin
                r_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.ir = prog_data;
                if (op_reads(cur_op)) begin
                    r_d.st = ST_READ;
                end else if (cur_op == OP_WAIT && cur_fld != '0) begin
                    wait_load = 1'b1;
                    r_d.st    = ST_WAIT;
                end else begin
                    if (cur_op == OP_SETB)  r_d.acc = alu_res;
                    if (cur_op == OP_STORE) we_c    = 1'b1;
                    r_d.pc = r_q.pc + 1'b1;
                    r_d.st = ST_FETCH;
                end
            end
            ST_READ: begin
                r_d.acc = alu_res;
                r_d.pc  = r_q.pc + 1'b1;
                r_d.st  = ST_FETCH;
            end
            ST_WAIT: begin
                if (wait_last) begin
                    r_d.pc = r_q.pc + 1'b1;
                    r_d.st = ST_FETCH;
                end
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= RST_VAL;
        else     r_q <= r_d;
    end

    assign prog_addr = r_q.pc;
    assign acc_o     = r_q.acc;
    assign reg_addr  = cur_fld;
    assign reg_wdata = r_q.acc[DW-1:0];
    assign reg_we    = we_c;

    // R11
    property pc_step_chk_p;
        @(posedge clk) disable iff (rst)
            (!$past(rst) && prog_addr != $past(prog_addr))
                |-> (prog_addr == PC_W'($past(prog_addr) + 1'b1));
    endproperty
    pc_step_chk: assert property (pc_step_chk_p)
        else $error("program counter moved by other than one");

    // R7
    property store_pulse_chk_p;
        @(posedge clk) disable iff (rst) reg_we |=> !reg_we;
    endproperty
    store_pulse_chk: assert property (store_pulse_chk_p)
        else $error("write strobe held for more than one cycle");

    // R7
    property store_keep_chk_p;
        @(posedge clk) disable iff (rst) reg_we |=> $stable(acc_o);
    endproperty
    store_keep_chk: assert property (store_keep_chk_p)
        else $error("store altered the accumulator");

    // R2 R3 R9
    property upper_src_chk_p;
        @(posedge clk) disable iff (rst)
            (!$past(rst) && acc_o[ACC_W-1:DW] != $past(acc_o[ACC_W-1:DW]))
                |-> ($past(r_q.st) == ST_READ && op_wide($past(r_q.ir[IW-1:DW])));
    endproperty
    upper_src_chk: assert property (upper_src_chk_p)
        else $error("upper accumulator bits changed outside an arithmetic op");

endmodule

// File: tb/acc_seq_bench.sv
`timescale 1ns/1ps
module acc_seq_bench;
    localparam int PC_W = 8;
    localparam int DW   = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  prog_addr;
    logic [11:0] prog_q;
    logic [7:0]  reg_addr, reg_rdata, reg_wdata;
    logic        reg_we;
    logic [23:0] acc_o;

    logic [11:0] rom [256];
    logic [7:0]  regs [256];

    int          n_run = 0;
    int          n_fail = 0;
    logic [23:0] acc_m;
    logic [7:0]  pc_m;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        prog_q    <= rom[prog_addr];
        reg_rdata <= regs[reg_addr];
        if (reg_we) regs[reg_addr] <= reg_wdata;
    end

    acc_seq #(.PC_W(PC_W), .DW(DW)) u_acc_seq (
        .clk       (clk),
        .rst       (rst),
        .prog_addr (prog_addr),
        .prog_data (prog_q),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .acc_o     (acc_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(tag, "reset pc", 32'(prog_addr), 32'd0);
        check(tag, "reset acc", 32'(acc_o), 32'd0);
        check(tag, "reset we", 32'(reg_we), 32'd0);
        rst   = 1'b0;
        acc_m = '0;
        pc_m  = '0;
    endtask

    task automatic step(input logic [3:0] op, input logic [7:0] fld, input string tag);
        int         dur;
        int         cnt;
        int         sv;
        logic [7:0] v;
        rom[pc_m] = {op, fld};
        v   = regs[fld];
        dur = 2;
        sv  = int'($signed(v));
        case (op)
            4'h3: begin acc_m[7:0] = v; dur = 3; end
            4'h4: acc_m[fld[2:0]] = fld[7];
            4'h5: begin acc_m = acc_m + {16'h0, v}; dur = 3; end
            4'h6: begin acc_m = acc_m + 24'(sv * 256); dur = 3; end
            4'h7: begin acc_m = acc_m - 24'(sv * 256); dur = 3; end
            4'h9: dur = int'(fld) + 2;
            default: ;
        endcase
        cnt = 0;
        while (prog_addr == pc_m && cnt < 400) begin
            @(negedge clk);
            cnt++;
        end
        check(tag, "cycles", 32'(cnt), 32'(dur));
        check(tag, "acc", 32'(acc_o), 32'(acc_m));
        if (op == 4'h8)
            check(tag, "stored reg", 32'(regs[fld]), 32'(acc_m[7:0]));
        else
            check(tag, "reg untouched", 32'(regs[fld]), 32'(v));
        pc_m = pc_m + 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            regs[i] = 8'((i * 37 + 11) & 255);
            rom[i]  = 12'h000;
        end
        regs[250] = 8'h80;
        regs[251] = 8'h7F;
        regs[252] = 8'hFF;
        regs[253] = 8'h01;
        regs[254] = 8'h00;

        // R1
        do_reset("R1");

        // R2
        step(4'h3, 8'd5, "R2");
        step(4'h3, 8'd200, "R2");
        step(4'h3, 8'd254, "R2");

        // R3: every position, both values, varying ignored bits
        for (int b = 0; b < 8; b++) begin
            for (int a = 0; a < 2; a++) begin
                step(4'h4, {1'(a), 4'((b * 3 + a * 5) & 15), 3'(b)}, "R3");
            end
        end

        // R4
        for (int i = 0; i < 16; i++) step(4'h5, 8'(i * 16 + 3), "R4");
        step(4'h5, 8'd252, "R4");

        // R5
        step(4'h6, 8'd250, "R5");
        step(4'h6, 8'd251, "R5");
        step(4'h6, 8'd252, "R5");
        for (int i = 0; i < 12; i++) step(4'h6, 8'(i * 21 + 1), "R5");

        // R6
        step(4'h7, 8'd250, "R6");
        step(4'h7, 8'd251, "R6");
        for (int i = 0; i < 12; i++) step(4'h7, 8'(i * 19 + 2), "R6");

        // R11: mixed sequence timings
        step(4'h3, 8'd7, "R11");
        step(4'h4, 8'h81, "R11");
        step(4'h8, 8'd90, "R11");

        // R1: reset in the middle of a program
        step(4'h6, 8'd251, "R1");
        do_reset("R1");

        // R10: wrap downward then upward
        step(4'h7, 8'd253, "R10");
        check("R10", "wrap down", 32'(acc_o), 32'h00FFFF00);
        step(4'h3, 8'd252, "R10");
        step(4'h5, 8'd253, "R10");
        check("R10", "wrap up", 32'(acc_o), 32'h0);
        step(4'h6, 8'd250, "R10");
        step(4'h6, 8'd250, "R10");

        // R7: store then reload
        for (int k = 0; k < 6; k++) begin
            step(4'h3, 8'(k * 11), "R7");
            step(4'h4, {1'(k & 1), 4'h0, 3'(k)}, "R7");
            step(4'h8, 8'(100 + k), "R7");
            step(4'h3, 8'(100 + k), "R7");
        end

        // R8
        step(4'h9, 8'd0, "R8");
        step(4'h9, 8'd1, "R8");
        step(4'h9, 8'd2, "R8");
        step(4'h9, 8'd5, "R8");
        step(4'h9, 8'd37, "R8");
        step(4'h9, 8'd255, "R8");
        step(4'h3, 8'd9, "R8");

        // R9
        step(4'h6, 8'd251, "R9");
        for (int o = 0; o < 16; o++) begin
            if (o < 3 || o > 9) step(4'(o), 8'(o * 13 + 40), "R9");
        end
        step(4'h5, 8'd253, "R9");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule